// File: doc/BRIEF.md
# Video timing reference monitor

The block watches a stream of video words, one word per clock when the valid input is high. It finds timing reference sequences, each made of an all-ones word, two all-zero words and a flag word, and reports them. A one-clock strobe tells whether the reference closed the active picture (end marker) or opened it (start marker).

From the distance between consecutive end markers it measures the line length in words. It also learns where in the line the start marker sits. A reference that arrives anywhere other than where the last measured line predicts raises a sticky sync-position alarm. The alarm stays up for at least one measured line length, restarts on every further misplaced reference, and is dropped only by an end marker that arrives once that hold has run out. Downstream logic uses the alarm to distrust line counting or raster assumptions until the stream settles again.

Top module: `vid_trs_monitor`

## Requirements
- R1: A reference is four consecutive accepted words: all ones, zero, zero, then a flag word. Flag bit 6 set marks an end marker and flag bit 6 clear marks a start marker. `eav_o` or `sav_o` is high for exactly the one clock that follows the edge accepting the flag word. An incomplete preamble (all ones, zero, flag) produces no strobe.
- R2: Words with `valid_i` low are ignored. They neither take part in the preamble nor advance the word position.
- R3: `line_len_o` is the number of accepted words from one end-marker flag word to the next. It reads 0 until two end markers have been seen, and it updates in the same clock as the `eav_o` strobe.
- R4: Until two end markers have been seen since reset, every reference raises `nsp_o`.
- R5: Once a length is known, `nsp_o` is raised by an end marker not exactly one measured line after the previous one. It is also raised by a start marker at a different offset from its end marker than the previous start marker had. `nsp_o` rises in the clock of the strobe. References in their expected places raise nothing.
- R6: After being raised, `nsp_o` stays high for at least the most recently measured line length in accepted words. An end marker arriving before that hold has elapsed does not clear it.
- R7: A misplaced reference while `nsp_o` is high restarts the hold from its own position.
- R8: `nsp_o` falls only together with an `eav_o` strobe, at the first in-place end marker whose word completes the hold.
- R9: While `rst_ni` is low, all outputs are 0 and all learned line state is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | DATA_W | Video word |
| valid_i | input | 1 | Word on data_i is accepted this clock |
| eav_o | output | 1 | End-marker strobe |
| sav_o | output | 1 | Start-marker strobe |
| nsp_o | output | 1 | Sticky sync-position alarm |
| line_len_o | output | LEN_W | Measured line length in words |

## Verification
The bench builds the block with its defaults: 10-bit words, flag bit 6 and a 12-bit length counter. Because line length is measured rather than fixed, lines of 12 and 14 words exercise learning, in-place tracking, misplaced start markers, retriggered holds and a length change within a few hundred clocks. A hold that spans an end marker, a retrigger that outlives the original hold, idle words carrying an all-ones value, and a truncated preamble are all reached with these values.

// File: rtl/vid_trs_pkg.sv
package vid_trs_pkg;
  typedef struct packed {
    logic hit;
    logic is_eav;
  } trs_evt_t;
endpackage

// File: rtl/vid_trs_detect.sv
module vid_trs_detect
  import vid_trs_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int FLAG_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output trs_evt_t          evt_o
);
  localparam int HIST = 3;
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] hist_q [HIST];

  // hist_q[0] newest accepted word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q[0] <= '0;
    else if (valid_i) hist_q[0] <= data_i;
  end

  for (genvar g = 1; g < HIST; g++) begin : g_hist
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[g] <= '0;
      else if (valid_i) hist_q[g] <= hist_q[g-1];
    end
  end

  logic pre_ok;
  assign pre_ok = (hist_q[2] == ONES) && (hist_q[1] == ZERO) && (hist_q[0] == ZERO);

  always_comb begin
    evt_o.hit    = valid_i && pre_ok;
    evt_o.is_eav = data_i[FLAG_BIT];
  end
endmodule

// File: rtl/vid_line_tracker.sv
module vid_line_tracker
  import vid_trs_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  trs_evt_t         evt_i,
  output logic             new_o,
  output logic [LEN_W-1:0] len_next_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] POS_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] pos_q, len_q, sav_pos_q;
  logic             have_eav_q, len_ok_q, sav_ok_q;
  logic             eav_hit, sav_hit;

  assign eav_hit = evt_i.hit && evt_i.is_eav;
  assign sav_hit = evt_i.hit && !evt_i.is_eav;

  // pos_q is the offset of the current word from the last end-marker flag word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '0;
      len_q      <= '0;
      sav_pos_q  <= '0;
      have_eav_q <= 1'b0;
      len_ok_q   <= 1'b0;
      sav_ok_q   <= 1'b0;
    end else if (valid_i) begin
      if (eav_hit) begin
        pos_q      <= LEN_W'(1);
        have_eav_q <= 1'b1;
        if (have_eav_q) begin
          len_q    <= pos_q;
          len_ok_q <= 1'b1;
        end
      end else if (pos_q != POS_MAX) begin
        pos_q <= pos_q + LEN_W'(1);
      end
      if (sav_hit && have_eav_q) begin
        sav_pos_q <= pos_q;
        sav_ok_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    new_o = 1'b0;
    if (eav_hit) new_o = !(len_ok_q && pos_q == len_q);
    if (sav_hit) new_o = !(len_ok_q && sav_ok_q && pos_q == sav_pos_q);
    len_next_o = (eav_hit && have_eav_q) ? pos_q : len_q;
  end

  assign len_o = len_q;
endmodule

// File: rtl/vid_nsp_hold.sv
module vid_nsp_hold #(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             eav_hit_i,
  input  logic             new_i,
  input  logic [LEN_W-1:0] load_len_i,
  output logic             nsp_o
);
  logic [LEN_W-1:0] hold_q;
  logic             nsp_q;

  // hold_q counts accepted words left, this word included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      nsp_q  <= 1'b0;
    end else if (valid_i) begin
      if (new_i) begin
        nsp_q  <= 1'b1;
        hold_q <= load_len_i;
      end else begin
        if (hold_q != '0) hold_q <= hold_q - LEN_W'(1);
        if (eav_hit_i && hold_q <= LEN_W'(1)) nsp_q <= 1'b0;
      end
    end
  end

  assign nsp_o = nsp_q;
endmodule

// File: rtl/vid_trs_monitor.sv
module vid_trs_monitor
  import vid_trs_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int FLAG_BIT = 6,
  parameter int LEN_W    = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              eav_o,
  output logic              sav_o,
  output logic              nsp_o,
  output logic [LEN_W-1:0]  line_len_o
);
  trs_evt_t         evt;
  logic             is_new;
  logic [LEN_W-1:0] len_next;
  logic             eav_q, sav_q;

  vid_trs_detect #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .valid_i(valid_i),
    .evt_o  (evt)
  );

  vid_line_tracker #(.LEN_W(LEN_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .evt_i     (evt),
    .new_o     (is_new),
    .len_next_o(len_next),
    .len_o     (line_len_o)
  );

  vid_nsp_hold #(.LEN_W(LEN_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .eav_hit_i (evt.hit && evt.is_eav),
    .new_i     (is_new),
    .load_len_i(len_next),
    .nsp_o     (nsp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eav_q <= 1'b0;
      sav_q <= 1'b0;
    end else begin
      eav_q <= evt.hit && evt.is_eav;
      sav_q <= evt.hit && !evt.is_eav;
    end
  end

  assign eav_o = eav_q;
  assign sav_o = sav_q;
endmodule

// File: rtl/vid_trs_monitor_chk.sv
module vid_trs_monitor_chk #(
  parameter int DATA_W = 10,
  parameter int LEN_W  = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic              valid_i,
  input logic              eav_o,
  input logic              sav_o,
  input logic              nsp_o,
  input logic [LEN_W-1:0]  line_len_o
);
  a_r1_one_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eav_o && sav_o));

  a_r1_eav_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_o |=> !eav_o);

  a_r1_sav_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sav_o |=> !sav_o);

  a_r3_len_with_eav: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_len_o) |-> eav_o);

  a_r5_rise_on_trs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nsp_o) |-> (eav_o || sav_o));

  a_r8_fall_on_eav: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nsp_o) |-> eav_o);

  a_r2_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !(eav_o || sav_o));
endmodule

bind vid_trs_monitor vid_trs_monitor_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .data_i    (data_i),
  .valid_i   (valid_i),
  .eav_o     (eav_o),
  .sav_o     (sav_o),
  .nsp_o     (nsp_o),
  .line_len_o(line_len_o)
);

// File: tb/vid_trs_monitor_test.sv
`timescale 1ns/1ps
module vid_trs_monitor_test;
  localparam int DW = 10;
  localparam int LW = 12;
  localparam logic [9:0] W1 = 10'h3FF, W0 = 10'h000, WE = 10'h274,
                         WS = 10'h200, WF = 10'h040;

  typedef struct packed {
    logic          v;
    logic [9:0]    d;
    logic          e;
    logic          s;
    logic          n;
    logic [LW-1:0] len;
  } vec_t;

  function automatic vec_t mk(logic v, logic [9:0] d, logic e, logic s,
                              logic n, logic [LW-1:0] len);
    vec_t r;
    r.v = v; r.d = d; r.e = e; r.s = s; r.n = n; r.len = len;
    return r;
  endfunction

  // three 12-word lines: end marker at index 3, start marker at index 9
  localparam int NV = 37;
  localparam vec_t TBL [NV] = '{
    mk(1,W1,0,0,0,0), mk(1,W0,0,0,0,0), mk(1,W0,0,0,0,0), mk(1,WE,1,0,1,0),
    mk(1,WF,0,0,1,0), mk(1,WF,0,0,1,0), mk(1,W1,0,0,1,0), mk(1,W0,0,0,1,0),
    mk(1,W0,0,0,1,0), mk(1,WS,0,1,1,0), mk(1,WF,0,0,1,0), mk(1,WF,0,0,1,0),
    mk(1,W1,0,0,1,0), mk(1,W0,0,0,1,0), mk(1,W0,0,0,1,0), mk(1,WE,1,0,1,12),
    mk(1,WF,0,0,1,12), mk(1,WF,0,0,1,12), mk(1,W1,0,0,1,12), mk(1,W0,0,0,1,12),
    mk(1,W0,0,0,1,12), mk(1,WS,0,1,1,12), mk(1,WF,0,0,1,12), mk(1,WF,0,0,1,12),
    mk(1,W1,0,0,1,12), mk(1,W0,0,0,1,12), mk(1,W0,0,0,1,12), mk(1,WE,1,0,0,12),
    mk(0,W1,0,0,0,12),
    mk(1,WF,0,0,0,12), mk(1,WF,0,0,0,12), mk(1,W1,0,0,0,12), mk(1,W0,0,0,0,12),
    mk(1,W0,0,0,0,12), mk(1,WS,0,1,0,12), mk(1,WF,0,0,0,12), mk(1,WF,0,0,0,12)
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data = '0;
  logic          valid = 1'b0;
  logic          eav, sav, nsp;
  logic [LW-1:0] len;

  int checks = 0;
  int failures = 0;

  logic seen_e, seen_s, nsp_at_e, nsp_at_s;

  always #2 clk = ~clk;

  vid_trs_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .eav_o(eav), .sav_o(sav), .nsp_o(nsp), .line_len_o(len)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(logic v, logic [9:0] d);
    valid = v;
    data  = d;
    @(negedge clk);
  endtask

  task automatic send_line(int n, int sav_idx);
    seen_e = 0; seen_s = 0; nsp_at_e = 0; nsp_at_s = 0;
    for (int i = 0; i < n; i++) begin
      logic [9:0] w;
      if (i == 0 || i == sav_idx - 3) w = W1;
      else if (i == 1 || i == 2 || i == sav_idx - 2 || i == sav_idx - 1) w = W0;
      else if (i == 3) w = WE;
      else if (i == sav_idx) w = WS;
      else w = WF;
      put(1, w);
      if (eav) begin seen_e = 1; nsp_at_e = nsp; end
      if (sav) begin seen_s = 1; nsp_at_s = nsp; end
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {eav, sav, nsp, len}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: R1 R2 R3 R4 R5 R6 R8
    for (int k = 0; k < NV; k++) begin
      put(TBL[k].v, TBL[k].d);
      chk($sformatf("R1/R2/R3/R4/R6/R8 vec %0d", k), {eav, sav, nsp, len},
          {TBL[k].e, TBL[k].s, TBL[k].n, TBL[k].len});
    end

    // R5: start marker at offset 4 instead of 6
    send_line(12, 7);
    chk("R5 misplaced sav strobe", seen_s, 1);
    chk("R5 misplaced sav raises nsp", nsp_at_s, 1);
    // R6: next end marker comes before hold elapsed
    send_line(12, 9);
    chk("R6 nsp held across early eav", nsp_at_e, 1);
    chk("R5 sav back at offset 6 is misplaced", nsp_at_s, 1);
    // R7: retrigger keeps nsp past where the first hold would end
    send_line(12, 9);
    chk("R7 retrigger extends hold", nsp_at_e, 1);
    send_line(14, 9);
    chk("R8 cleared by eav after hold", nsp_at_e, 0);
    chk("R8 in-place sav keeps nsp low", nsp_at_s, 0);
    // length change to 14
    send_line(14, 9);
    chk("R5 eav at new distance raises nsp", nsp_at_e, 1);
    chk("R3 new length", len, 14);
    send_line(14, 9);
    chk("R8 cleared after 14-word hold", nsp_at_e, 0);
    chk("R3 length stays", len, 14);

    // R9 mid-stream reset
    put(1, W1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears state", {eav, sav, nsp, len}, 0);
    rst_n = 1'b1;
    // R1 truncated preamble
    put(1, W1); put(1, W0); put(1, WE);
    chk("R1 truncated preamble no strobe", {eav, sav, nsp}, 0);
    // R2 idle word inside preamble is skipped
    put(1, W1); put(0, WF); put(1, W0); put(0, W1); put(1, W0); put(1, WE);
    chk("R2 idle words skipped in preamble", eav, 1);
    chk("R4 first eav after reset raises nsp", nsp, 1);
    chk("R9 length cleared by reset", len, 0);
    put(1, WF);
    chk("R1 strobe lasts one clock", eav, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule